// File: doc/BRIEF.md
# Line Frame and Superframe Synchronizer

This block sits behind the symbol decision stage of a basic-rate subscriber line receiver. It takes one quaternary symbol at a time, each a 2-bit code qualified by a valid strobe, and looks for the 9-symbol frame marker. The marker may arrive in its normal form or in its negated form. Once the marker has been seen at the same offset in two frames in a row, the block declares frame alignment. It then keeps a running symbol position and emits a one-cycle strobe at the end of every frame. The negated marker flags the first frame of an 8-frame superframe. After it is found under frame alignment, the block also tracks superframe alignment and strobes the last symbol of each superframe.

Alignment is dropped after three consecutive frames with no acceptable marker at the expected slot, and at once whenever the front end reports that the received signal is gone. Once superframe alignment is held, the marker polarity is checked as well: a marker with the wrong polarity for its frame counts as a miss. A separate timer raises a persistent loss flag when frame alignment has been absent for a set number of frame periods of received symbols. With the default of 320 frames this is 480 ms at 80 kbaud, and the activation controller uses the flag.

Top module: `line_frame_sync`

## Requirements
- R1: After reset, frame_sync_o, sframe_sync_o, frame_strobe_o, sframe_strobe_o and sync_loss_o are 0 and sym_pos_o is 0.
- R2: Symbol codes are 00=-3, 01=-1, 10=+1, 11=+3. The marker, oldest symbol first, is +3 +3 -3 -3 -3 +3 -3 +3 +3, and its negated form is -3 -3 +3 +3 +3 -3 +3 -3 -3. When no alignment is held, either form realigns the frame: after its ninth symbol, sym_pos_o reads 9.
- R3: sym_pos_o is the frame position (0 to FRAME_LEN-1) that the next valid symbol takes. It advances by one, modulo FRAME_LEN, for each valid symbol outside a realignment. It holds while sym_valid_i is 0.
- R4: frame_sync_o rises right after the ninth symbol of a marker that lands in the same slot one frame after the marker that realigned the frame. If that slot holds no marker, alignment is not declared.
- R5: While aligned, frame_sync_o falls right after the ninth symbol slot of the third consecutive frame without an acceptable marker. An accepted marker clears the miss count.
- R6: Under frame alignment with no superframe alignment, a negated marker sets sframe_sync_o and makes that frame number 0 of the superframe. A normal marker leaves sframe_sync_o at 0.
- R7: Under superframe alignment, frame 0 must carry the negated marker and frames 1 to 7 the normal one. A marker of the other polarity counts as a miss.
- R8: frame_strobe_o is high for exactly the one cycle after the edge that takes the last symbol of a frame while frame alignment is held.
- R9: sframe_strobe_o is high for the one cycle after the last symbol of frame 7 under superframe alignment, and at no other frame end.
- R10: sig_ok_i low at a clock edge clears frame_sync_o and sframe_sync_o at that edge.
- R11: sync_loss_o rises after LOSS_FRAMES*FRAME_LEN valid symbols have been taken without frame alignment. It clears one cycle after frame_sync_o rises.
- R12: sframe_sync_o is never high while frame_sync_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Symbol-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_valid_i | input | 1 | Symbol strobe |
| sym_i | input | 2 | Quaternary symbol code |
| sig_ok_i | input | 1 | Received signal present |
| frame_sync_o | output | 1 | Frame alignment held |
| sframe_sync_o | output | 1 | Superframe alignment held |
| sym_pos_o | output | $clog2(FRAME_LEN) | Position of the next symbol in the frame |
| frame_strobe_o | output | 1 | End-of-frame pulse |
| sframe_strobe_o | output | 1 | End-of-superframe pulse |
| sync_loss_o | output | 1 | Prolonged loss of frame alignment |

## Verification
The marker detector is combinational on the incoming symbol. As a result, position, frame alignment and superframe alignment all change at the edge that takes the ninth marker symbol. The two strobes appear one cycle after the edge that takes symbol 119, and the loss flag clears one cycle after alignment rises. The bench drives each symbol 2 ns after a rising edge, holds it for one edge, and samples the outputs at the same point after that edge. Every check is therefore tied to a known symbol index. The split frame tasks let the bench stop exactly at symbol 8, symbol 118 or symbol 119 and compare against values worked out from the requirements.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  // marker, oldest symbol in MSB; 1 = +3, 0 = -3
  localparam logic [8:0] SW_PATTERN = 9'b110001011;
  localparam int SW_LEN = $bits(SW_PATTERN);

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_CONF = 2'd1,
    ST_SYNC = 2'd2
  } sync_state_e;
endpackage

// File: rtl/lfs_word_det.sv
module lfs_word_det
  import lfs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [1:0] sym_i,
  output logic       pos_hit_o,
  output logic       neg_hit_o
);
  localparam int HW = 2 * (SW_LEN - 1);

  logic [HW-1:0]       hist_q;
  logic [2*SW_LEN-1:0] win;
  logic [SW_LEN-1:0]   eq_pos, eq_neg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= {(SW_LEN-1){2'b01}};
    else if (valid_i) hist_q <= {hist_q[HW-3:0], sym_i};
  end

  assign win = {hist_q, sym_i};

  for (genvar k = 0; k < SW_LEN; k++) begin : g_cmp
    localparam logic [1:0] REF = SW_PATTERN[k] ? 2'b11 : 2'b00;
    assign eq_pos[k] = (win[2*k+:2] == REF);
    assign eq_neg[k] = (win[2*k+:2] == ~REF);
  end

  assign pos_hit_o = valid_i & (&eq_pos);
  assign neg_hit_o = valid_i & (&eq_neg);
endmodule

// File: rtl/lfs_frame_trk.sv
module lfs_frame_trk
  import lfs_pkg::*;
#(
  parameter int FRAME_LEN  = 120,
  parameter int MISS_LIMIT = 3,
  parameter int POS_W      = $clog2(FRAME_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sig_ok_i,
  input  logic             hit_any_i,
  input  logic             exp_ok_i,
  output logic [POS_W-1:0] pos_o,
  output sync_state_e      state_o,
  output logic             lock_next_o,
  output logic             chk_o,
  output logic             wrap_o,
  output logic             fstb_o
);
  localparam int MISS_W = $clog2(MISS_LIMIT + 1);
  localparam logic [POS_W-1:0]  LAST_POS = POS_W'(FRAME_LEN - 1);
  localparam logic [POS_W-1:0]  CHK_POS  = POS_W'(SW_LEN - 1);
  localparam logic [POS_W-1:0]  START    = POS_W'(SW_LEN);
  localparam logic [MISS_W-1:0] MISS_MAX = MISS_W'(MISS_LIMIT - 1);

  sync_state_e      state_q, state_n;
  logic [POS_W-1:0] pos_q, pos_n;
  logic [MISS_W-1:0] miss_q, miss_n;

  assign chk_o  = valid_i && (pos_q == CHK_POS) && (state_q != ST_HUNT);
  assign wrap_o = valid_i && (pos_q == LAST_POS);

  always_comb begin
    state_n = state_q;
    pos_n   = pos_q;
    miss_n  = miss_q;
    if (valid_i) begin
      pos_n = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
      unique case (state_q)
        ST_HUNT: if (hit_any_i) begin
          pos_n   = START;
          state_n = ST_CONF;
          miss_n  = '0;
        end
        ST_CONF: if (chk_o) state_n = exp_ok_i ? ST_SYNC : ST_HUNT;
        ST_SYNC: if (chk_o) begin
          if (exp_ok_i) miss_n = '0;
          else if (miss_q == MISS_MAX) begin
            state_n = ST_HUNT;
            miss_n  = '0;
          end else miss_n = miss_q + 1'b1;
        end
        default: state_n = ST_HUNT;
      endcase
    end
    if (!sig_ok_i) begin
      state_n = ST_HUNT;
      miss_n  = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      pos_q   <= '0;
      miss_q  <= '0;
      fstb_o  <= 1'b0;
    end else begin
      state_q <= state_n;
      pos_q   <= pos_n;
      miss_q  <= miss_n;
      fstb_o  <= wrap_o && (state_q == ST_SYNC) && sig_ok_i;
    end
  end

  assign pos_o       = pos_q;
  assign state_o     = state_q;
  assign lock_next_o = (state_n == ST_SYNC);
endmodule

// File: rtl/lfs_sframe_trk.sv
module lfs_sframe_trk #(
  parameter int SF_FRAMES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chk_i,
  input  logic pos_hit_i,
  input  logic neg_hit_i,
  input  logic lock_next_i,
  input  logic wrap_i,
  input  logic sig_ok_i,
  output logic exp_ok_o,
  output logic sf_lock_o,
  output logic sstb_o
);
  localparam int FIDX_W = (SF_FRAMES > 1) ? $clog2(SF_FRAMES) : 1;
  localparam logic [FIDX_W-1:0] LAST_F = FIDX_W'(SF_FRAMES - 1);

  logic [FIDX_W-1:0] fidx_q;
  logic              sf_q;
  logic              anchor;

  // polarity is only enforced once the superframe is anchored
  assign exp_ok_o = sf_q ? ((fidx_q == '0) ? neg_hit_i : pos_hit_i)
                         : (pos_hit_i | neg_hit_i);
  assign anchor   = chk_i && neg_hit_i && !sf_q && lock_next_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fidx_q <= '0;
      sf_q   <= 1'b0;
      sstb_o <= 1'b0;
    end else begin
      if (!lock_next_i) sf_q <= 1'b0;
      else if (anchor)  sf_q <= 1'b1;
      if (anchor)      fidx_q <= '0;
      else if (wrap_i) fidx_q <= (fidx_q == LAST_F) ? '0 : fidx_q + 1'b1;
      sstb_o <= wrap_i && sf_q && (fidx_q == LAST_F) && sig_ok_i;
    end
  end

  assign sf_lock_o = sf_q;
endmodule

// File: rtl/lfs_loss_tmr.sv
module lfs_loss_tmr #(
  parameter int LOSS_SYMS = 38400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic in_sync_i,
  output logic lost_o
);
  localparam int CNT_W = $clog2(LOSS_SYMS + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LOSS_SYMS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lost_o <= 1'b0;
    end else if (in_sync_i) begin
      cnt_q  <= '0;
      lost_o <= 1'b0;
    end else if (valid_i && !lost_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LIM) lost_o <= 1'b1;
    end
  end
endmodule

// File: rtl/line_frame_sync.sv
module line_frame_sync
  import lfs_pkg::*;
#(
  parameter int FRAME_LEN   = 120,
  parameter int SF_FRAMES   = 8,
  parameter int MISS_LIMIT  = 3,
  parameter int LOSS_FRAMES = 320,
  localparam int POS_W      = $clog2(FRAME_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sym_valid_i,
  input  logic [1:0]       sym_i,
  input  logic             sig_ok_i,
  output logic             frame_sync_o,
  output logic             sframe_sync_o,
  output logic [POS_W-1:0] sym_pos_o,
  output logic             frame_strobe_o,
  output logic             sframe_strobe_o,
  output logic             sync_loss_o
);
  localparam int LOSS_SYMS = LOSS_FRAMES * FRAME_LEN;

  logic        pos_hit, neg_hit, exp_ok, lock_next, chk, wrap;
  sync_state_e state;

  lfs_word_det u_det (
    .clk_i, .rst_ni,
    .valid_i  (sym_valid_i),
    .sym_i,
    .pos_hit_o(pos_hit),
    .neg_hit_o(neg_hit)
  );

  lfs_frame_trk #(
    .FRAME_LEN(FRAME_LEN), .MISS_LIMIT(MISS_LIMIT), .POS_W(POS_W)
  ) u_frm (
    .clk_i, .rst_ni,
    .valid_i    (sym_valid_i),
    .sig_ok_i,
    .hit_any_i  (pos_hit | neg_hit),
    .exp_ok_i   (exp_ok),
    .pos_o      (sym_pos_o),
    .state_o    (state),
    .lock_next_o(lock_next),
    .chk_o      (chk),
    .wrap_o     (wrap),
    .fstb_o     (frame_strobe_o)
  );

  lfs_sframe_trk #(.SF_FRAMES(SF_FRAMES)) u_sf (
    .clk_i, .rst_ni,
    .chk_i      (chk),
    .pos_hit_i  (pos_hit),
    .neg_hit_i  (neg_hit),
    .lock_next_i(lock_next),
    .wrap_i     (wrap),
    .sig_ok_i,
    .exp_ok_o   (exp_ok),
    .sf_lock_o  (sframe_sync_o),
    .sstb_o     (sframe_strobe_o)
  );

  lfs_loss_tmr #(.LOSS_SYMS(LOSS_SYMS)) u_loss (
    .clk_i, .rst_ni,
    .valid_i  (sym_valid_i),
    .in_sync_i(state == ST_SYNC),
    .lost_o   (sync_loss_o)
  );

  assign frame_sync_o = (state == ST_SYNC);
endmodule

// File: rtl/line_frame_sync_chk.sv
module line_frame_sync_chk #(
  parameter int FRAME_LEN = 120,
  parameter int SW_LEN    = 9,
  localparam int POS_W    = $clog2(FRAME_LEN)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sym_valid_i,
  input logic             sig_ok_i,
  input logic             frame_sync_o,
  input logic             sframe_sync_o,
  input logic [POS_W-1:0] sym_pos_o,
  input logic             frame_strobe_o,
  input logic             sframe_strobe_o
);
  assert_pos_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(sym_pos_o) < FRAME_LEN);

  assert_pos_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_valid_i |=> $stable(sym_pos_o));

  assert_pos_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && frame_sync_o) |=>
      int'(sym_pos_o) == ((int'($past(sym_pos_o)) + 1) % FRAME_LEN));

  assert_lock_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_sync_o) |-> int'(sym_pos_o) == SW_LEN);

  assert_sf_anchor_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sframe_sync_o) |-> int'(sym_pos_o) == SW_LEN);

  assert_fstb_sync_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_strobe_o |-> $past(frame_sync_o));

  assert_sstb_in_fstb_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sframe_strobe_o |-> frame_strobe_o);

  assert_sig_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sig_ok_i |=> (!frame_sync_o && !sframe_sync_o));

  assert_sf_needs_frame_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sframe_sync_o |-> frame_sync_o);
endmodule

bind line_frame_sync line_frame_sync_chk #(
  .FRAME_LEN(FRAME_LEN), .SW_LEN(lfs_pkg::SW_LEN)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sym_valid_i    (sym_valid_i),
  .sig_ok_i       (sig_ok_i),
  .frame_sync_o   (frame_sync_o),
  .sframe_sync_o  (sframe_sync_o),
  .sym_pos_o      (sym_pos_o),
  .frame_strobe_o (frame_strobe_o),
  .sframe_strobe_o(sframe_strobe_o)
);

// File: tb/line_frame_sync_bench.sv
`timescale 1ns/1ps
module line_frame_sync_bench;
  localparam int FL    = 120;
  localparam int WL    = 9;
  localparam int LOSSF = 4;
  localparam logic [8:0] PAT = 9'b110001011;
  localparam int K_NONE = 0, K_POS = 1, K_NEG = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [1:0] sym = 2'b01;
  logic       sig_ok = 1'b1;
  logic       fsync, sfsync, fstb, sfstb, lost;
  logic [6:0] pos;
  logic       pay_t = 1'b0;
  int         tests = 0, fails = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  line_frame_sync #(.LOSS_FRAMES(LOSSF)) u_line_frame_sync (
    .clk_i(clk), .rst_ni(rst_n), .sym_valid_i(valid), .sym_i(sym),
    .sig_ok_i(sig_ok), .frame_sync_o(fsync), .sframe_sync_o(sfsync),
    .sym_pos_o(pos), .frame_strobe_o(fstb), .sframe_strobe_o(sfstb),
    .sync_loss_o(lost)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // drive 2 ns after a rising edge, one edge per symbol, sample at the same point
  task automatic send_sym(input logic [1:0] c);
    sym   = c;
    valid = 1'b1;
    @(posedge clk);
    #2 valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic send_pay(input int n);
    for (int i = 0; i < n; i++) begin
      send_sym(pay_t ? 2'b10 : 2'b01);
      pay_t = ~pay_t;
    end
  endtask

  task automatic send_part(input int kind, input int from, input int upto);
    for (int i = from; i < upto; i++) begin
      if (i < WL && kind != K_NONE) begin
        logic [1:0] c;
        c = PAT[WL-1-i] ? 2'b11 : 2'b00;
        if (kind == K_NEG) c = ~c;
        send_sym(c);
      end else send_pay(1);
    end
  endtask

  task automatic send_frame(input int kind);
    send_part(kind, 0, FL);
  endtask

  initial begin
    #(8 * 200000);
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    fails++;
    tests++;
    finish_run();
  end

  initial begin
    #3;
    chk("R1 fsync", fsync, 0);
    chk("R1 sfsync", sfsync, 0);
    chk("R1 pos", pos, 0);
    chk("R1 fstb", fstb, 0);
    chk("R1 sfstb", sfstb, 0);
    chk("R1 lost", lost, 0);
    #7 rst_n = 1'b1;
    @(posedge clk); #2;

    // free running position, hold while idle
    send_pay(37);
    chk("R3 pos count", pos, 37);
    idle(3);
    chk("R3 pos hold", pos, 37);

    // first marker realigns
    send_part(K_POS, 0, WL);
    chk("R2 realign pos", pos, WL);
    chk("R4 no lock yet", fsync, 0);
    send_part(K_POS, WL, FL);
    chk("R3 wrap", pos, 0);

    // missing confirm word: back to hunt
    send_part(K_NONE, 0, WL);
    chk("R4 no confirm", fsync, 0);
    send_part(K_NONE, WL, FL);
    send_part(K_POS, 0, WL);
    chk("R4 first of two", fsync, 0);
    send_part(K_POS, WL, FL);

    send_part(K_POS, 0, WL-1);
    chk("R4 before 9th", fsync, 0);
    send_part(K_POS, WL-1, WL);
    chk("R4 lock", fsync, 1);
    chk("R6 pos word no sf", sfsync, 0);
    send_part(K_POS, WL, FL-1);
    chk("R8 strobe early", fstb, 0);
    send_part(K_POS, FL-1, FL);
    chk("R8 strobe", fstb, 1);
    chk("R9 no sf strobe", sfstb, 0);
    idle(1);
    chk("R8 strobe width", fstb, 0);

    // misses: 2, hit clears, 2 more, third drops
    send_frame(K_NONE);
    send_frame(K_NONE);
    chk("R5 two misses", fsync, 1);
    send_frame(K_POS);
    send_frame(K_NONE);
    send_frame(K_NONE);
    chk("R5 count cleared", fsync, 1);
    send_part(K_NONE, 0, WL);
    chk("R5 third miss", fsync, 0);
    send_part(K_NONE, WL, FL);

    // reacquire, anchor superframe with negated word
    send_frame(K_POS);
    send_part(K_NEG, 0, WL);
    chk("R4 relock", fsync, 1);
    chk("R6 sf anchor", sfsync, 1);
    chk("R11 no loss", lost, 0);
    send_part(K_NEG, WL, FL);
    chk("R9 frame0 end", sfstb, 0);
    for (int f = 1; f < 8; f++) begin
      send_part(K_POS, 0, FL-1);
      send_part(K_POS, FL-1, FL);
      chk("R8 each frame", fstb, 1);
      chk("R9 sf strobe", sfstb, (f == 7) ? 1 : 0);
    end
    send_frame(K_NEG);
    chk("R7 neg at frame0", sfsync, 1);

    // wrong polarity at frames 1..3
    send_frame(K_NEG);
    send_frame(K_NEG);
    chk("R7 two wrong", fsync, 1);
    send_part(K_NEG, 0, WL);
    chk("R7 third wrong", fsync, 0);
    chk("R12 sf drops", sfsync, 0);
    send_part(K_NEG, WL, FL);

    // hunt and confirm on negated words
    send_frame(K_NEG);
    send_part(K_NEG, 0, WL);
    chk("R6 sf on confirm", sfsync, 1);
    send_part(K_NEG, WL, FL);
    send_part(K_POS, 0, 50);

    // signal loss
    sig_ok = 1'b0;
    idle(1);
    sig_ok = 1'b1;
    chk("R10 fsync", fsync, 0);
    chk("R10 sfsync", sfsync, 0);
    chk("R3 pos kept", pos, 50);

    // prolonged loss
    send_pay(LOSSF*FL - 1);
    chk("R11 below limit", lost, 0);
    send_pay(1);
    chk("R11 at limit", lost, 1);
    send_frame(K_POS);
    send_part(K_POS, 0, WL);
    chk("R4 lock after loss", fsync, 1);
    chk("R11 held at lock", lost, 1);
    send_part(K_POS, WL, WL+1);
    chk("R11 cleared", lost, 0);

    finish_run();
  end
endmodule